// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan timing for a display pipeline. Software programs the visible area, the front porch, the sync pulse widths and the total line and frame lengths through a small 32-bit register bus. Each timing register packs the vertical value into the upper half-word and the horizontal value into the lower half-word. The block then walks a pixel counter and a line counter on the pixel clock and drives active-low sync strobes, a data-enable flag and the current pixel coordinates.

Within a line, the pixel counter passes through the visible pixels, then the front porch, then the sync pulse, and then the back porch. The back porch is whatever the programmed total leaves over. The line counter uses the same order, one step per completed line. Timing writes go to a live register set, and a working copy takes them at the next frame boundary, so a frame in progress is never torn. The status register also holds a pixel-format code, a clock-select index and a frame base address. The block only stores these and drives them out to the fetch and clock logic next to it.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads 0, `de` is 0, `hsync_n` and `vsync_n` are 1, `pix_x`, `pix_y`, `clk_sel`, `pix_fmt` and `fb_base` are 0.
- R2: Registers sit at byte offsets 0x00 (status), 0x04 (visible size), 0x08 (front porch), 0x0C (sync width), 0x10 (total length) and 0x14 (frame base). A write with `bus_wr` high lands on the next clock edge. `bus_rdata` returns the live contents of `bus_addr` in the same cycle, and 0 for any other offset.
- R3: Bits [31:16] of the visible-size register hold visible lines minus one, and bits [15:0] hold visible pixels minus one. `de` is high exactly when the block is enabled, `pix_x` is at most the pixel field and `pix_y` is at most the line field.
- R4: Bits [15:0] of the total register hold pixels per line minus one, and bits [31:16] hold lines per frame minus one. While enabled, `pix_x` steps by one each clock and wraps from that limit to 0. `pix_y` steps only when `pix_x` wraps, and wraps from its own limit to 0.
- R5: `hsync_n` is low for the number of pixels given in sync bits [15:0]. The pulse starts at pixel (visible pixels + front porch bits [15:0]).
- R6: `vsync_n` is low during the number of whole lines given in sync bits [31:16]. The pulse starts at line (visible lines + front porch bits [31:16]).
- R7: While status bit 0 is 0, `pix_x` and `pix_y` are held at 0, `de` is 0 and both syncs are 1. Enabling starts the scan at pixel 0 of line 0.
- R8: Status bit 0 is the enable, bits [5:4] drive `pix_fmt` and bits [7:6] drive `clk_sel`. All other status bits read 0.
- R9: The frame base register ignores bits [1:0] of a write. It reads back with them as 0 and drives `fb_base` with them as 0.
- R10: Writes to the four timing registers while enabled do not alter the frame in progress. They take effect together from the first pixel of the next frame.
- R11: A sync width of 0 produces no sync pulse on that axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-area flag |
| pix_x | output | CNT_W | Current pixel index in the line |
| pix_y | output | CNT_W | Current line index in the frame |
| clk_sel | output | 2 | Stored pixel-clock index |
| pix_fmt | output | 2 | Stored pixel-format code |
| fb_base | output | 32 | Word-aligned frame base address |

## Verification
A register write lands on the first clock edge after the strobe. A read returns data in the same cycle. Every scan output is decoded directly from the two counters, so a change appears right after the edge that moves a counter. An enable takes hold one edge after its write, and a timing write takes effect from the first frame boundary after that. The bench keeps its own counter model, fed from the bus at the same edges as the design, and compares position, `de` and both syncs at every falling edge. It also counts the sync-low, visible and per-line cycles across exact whole frames and compares those counts with totals worked out arithmetically from the programmed fields, so any shift by even one cycle changes a count.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int HALF_W = 16;

   // byte offsets of the register set
   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_SIZE  = 'h04;
   localparam int OFS_PORCH = 'h08;
   localparam int OFS_PULSE = 'h0C;
   localparam int OFS_SPAN  = 'h10;
   localparam int OFS_BASE  = 'h14;

   typedef struct packed {
      logic [HALF_W-1:0] v;
      logic [HALF_W-1:0] h;
   } axis_pair_t;

   typedef struct packed {
      axis_pair_t size;   // visible minus one
      axis_pair_t porch;  // front porch
      axis_pair_t pulse;  // sync width
      axis_pair_t span;   // total minus one
   } scan_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              frame_end,
   output logic              ctl_en,
   output logic [1:0]        clk_sel,
   output logic [1:0]        pix_fmt,
   output logic [31:0]       fb_base,
   output scan_cfg_t         work_cfg
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(OFS_SIZE);
   localparam logic [ADDR_W-1:0] A_PORCH = ADDR_W'(OFS_PORCH);
   localparam logic [ADDR_W-1:0] A_PULSE = ADDR_W'(OFS_PULSE);
   localparam logic [ADDR_W-1:0] A_SPAN  = ADDR_W'(OFS_SPAN);
   localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);

   scan_cfg_t   live_cfg;
   logic [29:0] base_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en    <= 1'b0;
         clk_sel   <= 2'd0;
         pix_fmt   <= 2'd0;
         base_word <= '0;
         live_cfg  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_CTRL: begin
               ctl_en  <= bus_wdata[0];
               pix_fmt <= bus_wdata[5:4];
               clk_sel <= bus_wdata[7:6];
            end
            A_SIZE:  live_cfg.size  <= bus_wdata;
            A_PORCH: live_cfg.porch <= bus_wdata;
            A_PULSE: live_cfg.pulse <= bus_wdata;
            A_SPAN:  live_cfg.span  <= bus_wdata;
            A_BASE:  base_word      <= bus_wdata[31:2];
            default: ;
         endcase
      end
   end

   // working copy: follows the live set while idle, frozen across a frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         work_cfg <= '0;
      else if (!ctl_en || frame_end)
         work_cfg <= live_cfg;
   end

   assign fb_base = {base_word, 2'b00};

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = {24'd0, clk_sel, pix_fmt, 3'd0, ctl_en};
         A_SIZE:  bus_rdata = live_cfg.size;
         A_PORCH: bus_rdata = live_cfg.porch;
         A_PULSE: bus_rdata = live_cfg.pulse;
         A_SPAN:  bus_rdata = live_cfg.span;
         A_BASE:  bus_rdata = fb_base;
         default: bus_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         at_end
);
   assign at_end = (count >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (!run)
         count <= '0;
      else if (step)
         count <= at_end ? '0 : count + W'(1);
   end
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
   parameter int W = 16
) (
   input  logic [W-1:0] count,
   input  logic [W-1:0] act_last,
   input  logic [W-1:0] porch,
   input  logic [W-1:0] width,
   output logic         in_active,
   output logic         in_sync
);
   localparam int SW = W + 2;

   logic [SW-1:0] pos;
   logic [SW-1:0] sync_lo;
   logic [SW-1:0] sync_hi;

   assign pos       = SW'(count);
   assign sync_lo   = SW'(act_last) + SW'(porch) + SW'(1);
   assign sync_hi   = sync_lo + SW'(width);
   assign in_active = (count <= act_last);
   assign in_sync   = (pos >= sync_lo) && (pos < sync_hi);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              de,
   output logic [CNT_W-1:0]  pix_x,
   output logic [CNT_W-1:0]  pix_y,
   output logic [1:0]        clk_sel,
   output logic [1:0]        pix_fmt,
   output logic [31:0]       fb_base
);
   localparam int N_AXIS = 2;

   if (CNT_W < 2 || CNT_W > HALF_W) begin : g_bad_cnt_w
      $error("raster_timing_gen: CNT_W must lie in 2..16");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("raster_timing_gen: ADDR_W too small for the register set");
   end

   function automatic logic [CNT_W-1:0] pick(input axis_pair_t p, input int ax);
      return (ax == 0) ? p.h[CNT_W-1:0] : p.v[CNT_W-1:0];
   endfunction

   logic             ctl_en;
   logic             frame_end;
   scan_cfg_t        shd;
   logic [CNT_W-1:0] cnt     [N_AXIS];
   logic [N_AXIS-1:0] wrap;
   logic [N_AXIS-1:0] step;
   logic [N_AXIS-1:0] in_act;
   logic [N_AXIS-1:0] in_sync;

   rtg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .frame_end (frame_end),
      .ctl_en    (ctl_en),
      .clk_sel   (clk_sel),
      .pix_fmt   (pix_fmt),
      .fb_base   (fb_base),
      .work_cfg  (shd)
   );

   for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
      if (a == 0) begin : g_pixel
         assign step[a] = 1'b1;
      end else begin : g_line
         assign step[a] = wrap[a-1];
      end

      rtg_axis_cnt #(.W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (ctl_en),
         .step   (step[a]),
         .limit  (pick(shd.span, a)),
         .count  (cnt[a]),
         .at_end (wrap[a])
      );

      rtg_window #(.W(CNT_W)) u_win (
         .count     (cnt[a]),
         .act_last  (pick(shd.size, a)),
         .porch     (pick(shd.porch, a)),
         .width     (pick(shd.pulse, a)),
         .in_active (in_act[a]),
         .in_sync   (in_sync[a])
      );
   end

   assign frame_end = ctl_en & (&wrap);
   assign pix_x     = cnt[0];
   assign pix_y     = cnt[1];
   assign de        = ctl_en & (&in_act);
   assign hsync_n   = ~(ctl_en & in_sync[0]);
   assign vsync_n   = ~(ctl_en & in_sync[1]);
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             de,
   input logic [CNT_W-1:0] pix_x,
   input logic [CNT_W-1:0] pix_y,
   input logic [CNT_W-1:0] tot_h,
   input logic [CNT_W-1:0] act_h,
   input logic [CNT_W-1:0] act_v
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // R7: one cycle after an idle cycle the counters sit at zero
   assert_idle_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (pix_x == '0 && pix_y == '0));

   // R4: pixel index advances by one inside a line
   assert_x_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pix_x != '0) |-> pix_x == $past(pix_x) + ONE);

   // R4: a return to pixel zero only follows the programmed last pixel
   assert_x_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pix_x == '0) |-> $past(pix_x) == $past(tot_h));

   // R4: the line index holds while the pixel index has not wrapped
   assert_y_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pix_x != '0) |-> pix_y == $past(pix_y));

   // R3: data enable only inside the visible rectangle
   assert_de_area_R3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (pix_x <= act_h && pix_y <= act_v));
endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) u_rtg_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (ctl_en),
   .de    (de),
   .pix_x (pix_x),
   .pix_y (pix_y),
   .tot_h (shd.span.h[CNT_W-1:0]),
   .act_h (shd.size.h[CNT_W-1:0]),
   .act_v (shd.size.v[CNT_W-1:0])
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
   localparam int ADDR_W = 8;
   localparam int CNT_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              hsync_n, vsync_n, de;
   logic [CNT_W-1:0]  pix_x, pix_y;
   logic [1:0]        clk_sel, pix_fmt;
   logic [31:0]       fb_base;

   int total = 0;
   int bad   = 0;
   bit chk_on = 1'b0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   raster_timing_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync_n(hsync_n),
      .vsync_n(vsync_n), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .clk_sel(clk_sel), .pix_fmt(pix_fmt), .fb_base(fb_base)
   );

   // reference model driven from the bus at the same edges as the design
   logic        m_en;
   logic [31:0] l_act, l_fp, l_sw, l_tot;
   logic [31:0] c_act, c_fp, c_sw, c_tot;
   int          mh, mv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en <= 1'b0; mh <= 0; mv <= 0;
         l_act <= 0; l_fp <= 0; l_sw <= 0; l_tot <= 0;
         c_act <= 0; c_fp <= 0; c_sw <= 0; c_tot <= 0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               8'h00: m_en  <= bus_wdata[0];
               8'h04: l_act <= bus_wdata;
               8'h08: l_fp  <= bus_wdata;
               8'h0C: l_sw  <= bus_wdata;
               8'h10: l_tot <= bus_wdata;
               default: ;
            endcase
         end
         if (!m_en) begin
            mh <= 0; mv <= 0;
            c_act <= l_act; c_fp <= l_fp; c_sw <= l_sw; c_tot <= l_tot;
         end else if (mh == int'(c_tot[15:0])) begin
            mh <= 0;
            if (mv == int'(c_tot[31:16])) begin
               mv <= 0;
               c_act <= l_act; c_fp <= l_fp; c_sw <= l_sw; c_tot <= l_tot;
            end else begin
               mv <= mv + 1;
            end
         end else begin
            mh <= mh + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (chk_on && !done) begin
         int ha, hf, hw, va, vf, vw;
         bit e_de, e_hs, e_vs;
         ha = int'(c_act[15:0]);  va = int'(c_act[31:16]);
         hf = int'(c_fp[15:0]);   vf = int'(c_fp[31:16]);
         hw = int'(c_sw[15:0]);   vw = int'(c_sw[31:16]);
         e_de = m_en && mh <= ha && mv <= va;
         e_hs = !(m_en && mh >= ha + hf + 1 && mh < ha + hf + 1 + hw);
         e_vs = !(m_en && mv >= va + vf + 1 && mv < va + vf + 1 + vw);
         check(pix_x == CNT_W'(mh) && pix_y == CNT_W'(mv), "R4 R7 R10",
               "position", {pix_y, pix_x}, {mv[15:0], mh[15:0]});
         check(de == e_de, "R3", "de", de, e_de);
         check(hsync_n == e_hs, "R5 R11", "hsync_n", hsync_n, e_hs);
         check(vsync_n == e_vs, "R6", "vsync_n", vsync_n, e_vs);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(bus_rdata == exp, req, "read", bus_rdata, exp);
   endtask

   task automatic wait_origin();
      @(negedge clk);
      while (!(pix_x == 0 && pix_y == 0)) @(negedge clk);
   endtask

   // count low syncs and visible cycles over n cycles starting at the current negedge
   task automatic measure(input int n, input int e_hs, input int e_vs, input int e_de,
                          input string hreq);
      int nh = 0, nv = 0, nd = 0;
      for (int k = 0; k < n; k++) begin
         if (!hsync_n) nh++;
         if (!vsync_n) nv++;
         if (de) nd++;
         @(negedge clk);
      end
      check(nh == e_hs, hreq, "hsync low count", nh, e_hs);
      check(nv == e_vs, "R6", "vsync low count", nv, e_vs);
      check(nd == e_de, "R3", "visible count", nd, e_de);
      check(pix_x == 0 && pix_y == 0, "R4", "frame length", {pix_y, pix_x}, 0);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(de == 0 && hsync_n == 1 && vsync_n == 1, "R1", "idle outputs",
            {de, hsync_n, vsync_n}, 3'b011);
      check(pix_x == 0 && pix_y == 0, "R1", "coords", {pix_y, pix_x}, 0);
      check(fb_base == 0 && clk_sel == 0 && pix_fmt == 0, "R1", "exports",
            {fb_base, clk_sel, pix_fmt}, 0);
      rd(8'h00, 32'h0, "R1");
      rd(8'h10, 32'h0, "R1");
      chk_on = 1'b1;

      // configuration A: 4x3 visible, 10x7 total
      wr(8'h04, 32'h0002_0003);
      wr(8'h08, 32'h0001_0001);
      wr(8'h0C, 32'h0001_0002);
      wr(8'h10, 32'h0006_0009);
      wr(8'h14, 32'h1234_567B);
      wr(8'h00, 32'hFFFF_FFB0);
      rd(8'h04, 32'h0002_0003, "R2");
      rd(8'h08, 32'h0001_0001, "R2");
      rd(8'h0C, 32'h0001_0002, "R2");
      rd(8'h10, 32'h0006_0009, "R2");
      rd(8'h18, 32'h0, "R2");
      rd(8'h14, 32'h1234_5678, "R9");
      check(fb_base == 32'h1234_5678, "R9", "fb_base", fb_base, 32'h1234_5678);
      rd(8'h00, 32'h0000_00B0, "R8");
      check(clk_sel == 2'd2 && pix_fmt == 2'd3, "R8", "clk_sel/pix_fmt",
            {clk_sel, pix_fmt}, 4'b1011);

      repeat (5) @(negedge clk);
      check(pix_x == 0 && pix_y == 0 && !de && hsync_n && vsync_n, "R7",
            "held while idle", {pix_y, pix_x}, 0);

      wr(8'h00, 32'h0000_0071);
      check(clk_sel == 2'd1 && pix_fmt == 2'd3, "R8", "export after enable",
            {clk_sel, pix_fmt}, 4'b0111);
      repeat (2) @(negedge clk);
      wait_origin();
      measure(70, 14, 10, 12, "R5");

      // mid-frame rewrite to configuration B: 6x2 visible, 8x5 total, no hsync
      while (pix_y != 1) @(negedge clk);
      wr(8'h04, 32'h0001_0005);
      wr(8'h08, 32'h0000_0000);
      wr(8'h0C, 32'h0002_0000);
      wr(8'h10, 32'h0004_0007);
      rd(8'h10, 32'h0004_0007, "R2");
      check(pix_y <= 2, "R10", "old frame still running", pix_y, 2);
      wait_origin();
      begin
         int len = 0;
         do begin
            len++;
            @(negedge clk);
         end while (pix_x != 0);
         check(len == 8, "R10", "new line length", len, 8);
      end
      wait_origin();
      measure(40, 0, 16, 12, "R11");
      measure(40, 0, 16, 12, "R11");

      // disable mid-frame
      repeat (13) @(negedge clk);
      wr(8'h00, 32'h0000_0070);
      @(negedge clk);
      check(pix_x == 0 && pix_y == 0 && !de && hsync_n && vsync_n, "R7",
            "stop returns home", {pix_y, pix_x, de}, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule